// File: doc/BRIEF.md
# Markov Correlation Miss Prefetcher

This block learns, from the stream of instruction L1 miss addresses alone, which miss tends to come after which. It keeps a finite correlation table in which every entry is keyed by one earlier miss and holds up to four successor addresses that followed it. Hits in the L1 are never seen.

Each incoming miss is looked up in the table. On a hit, the stored successors go into a small request queue. That queue feeds the fill path of a prefetch buffer that sits beside the L1. On a lookup that finds nothing, no request goes out and the miss gets a fresh entry. In the same cycle, the current miss is recorded as a successor of the miss before it. A history of one miss is enough to train the table.

The cache arrays, the lower memory levels and the prefetch buffer storage lie outside this block. Its only interfaces are a miss strobe and a request stream with a valid/ready handshake.

Top module: `markov_prefetcher`

## Requirements
- R1: An active-low reset empties the request queue (pfValid low), invalidates every table entry and forgets the previous miss. The first miss after reset therefore trains nothing, and no miss address predicts anything until it has been trained again.
- R2: A miss whose address finds no valid entry with a matching tag issues no request and installs an entry for that address with all four successor slots empty.
- R3: When miss X is followed by miss Y, Y is recorded as a successor of X. A later miss of X then issues a request for Y.
- R4: On a hit, the entry's valid successors are requested one per cycle, most recently seen first. An entry holds at most four successors.
- R5: A successor that is already stored moves to the front of the order without being duplicated. The other successors keep their relative order.
- R6: A new successor enters at the front. When all four slots are full, the least recently seen successor is discarded.
- R7: The table has 64 entries and is direct-mapped. Miss address bits [5:0] select the entry and the remaining bits form its tag. A miss that maps onto an entry holding another tag overwrites that entry and clears its successors.
- R8: Requests pass through a 4-deep queue and leave one per accepted handshake. pfAddr holds steady while pfValid is high and pfReady is low. Predictions that find the queue full are dropped in slot order, while the earlier slots are still accepted.
- R9: Training is skipped when the previous miss's entry has been evicted in the meantime, including when the current miss evicted it in the same cycle.
- R10: A miss that hits an entry with at least one successor, arriving while the queue is empty, raises pfValid on the next cycle with the front successor on pfAddr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | An instruction L1 miss is presented this cycle |
| missAddr | input | ADDR_W (32) | Line address of the miss |
| pfReady | input | 1 | Consumer accepts the request on pfAddr |
| pfValid | output | 1 | A prefetch request is pending |
| pfAddr | output | ADDR_W (32) | Line address to prefetch |

## Verification
The bench trains one entry up to four successors and reads back the request order at each step. It then revisits an existing successor and adds a fifth. A design with a plain insertion order would emit stale addresses first, and one without a search would show a duplicate or lose the wrong address. It also forces a same-index conflict, where a design that clears no slots or trains into the newly installed entry would return extra requests. Finally it holds pfReady low while four misses arrive back to back, which catches a queue that overflows, changes its head under backpressure or drops a whole group instead of only its tail.

// File: rtl/mkv_pkg.sv
package mkv_pkg;

  // Strobes the control issues to the table datapath each cycle
  typedef struct packed {
    logic lookupEn;     // a miss is presented, compare against the table
    logic insertEn;     // install the current miss as a fresh entry
    logic trainEn;      // record current miss as successor of the previous one
    logic capturePrev;  // remember the current miss for the next cycle
    logic issueEn;      // hand the hit entry's successors to the queue
  } mkv_strobe_t;

endpackage

// File: rtl/mkv_ctrl.sv
module mkv_ctrl
  import mkv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missValid,
  input  logic        tableHit,
  output mkv_strobe_t strobe
);

  logic prevValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevValid <= 1'b0;
    else if (missValid) prevValid <= 1'b1;
  end

  always_comb begin
    strobe.lookupEn    = missValid;
    strobe.insertEn    = missValid && !tableHit;
    strobe.trainEn     = missValid && prevValid;
    strobe.capturePrev = missValid;
    strobe.issueEn     = missValid && tableHit;
  end

endmodule

// File: rtl/mkv_mtf.sv
// Move-to-front update of one entry's successor list.
module mkv_mtf #(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 4
) (
  input  logic [SLOTS-1:0]             oldVld,
  input  logic [SLOTS-1:0][ADDR_W-1:0] oldAddr,
  input  logic [ADDR_W-1:0]            newAddr,
  output logic [SLOTS-1:0]             newVld,
  output logic [SLOTS-1:0][ADDR_W-1:0] newAddrs
);

  // match on slot i; the last slot never needs to stop the shift
  logic [SLOTS-2:0] match;
  logic [SLOTS-2:0] seen;

  assign newVld[0]   = 1'b1;
  assign newAddrs[0] = newAddr;

  for (genvar g = 0; g < SLOTS - 1; g++) begin : g_match
    assign match[g] = oldVld[g] && (oldAddr[g] == newAddr);
    if (g == 0) begin : g_first
      assign seen[g] = match[g];
    end else begin : g_rest
      assign seen[g] = seen[g-1] | match[g];
    end
  end

  // slot g takes its left neighbour until the repeat (or the end) is passed
  for (genvar g = 1; g < SLOTS; g++) begin : g_shift
    assign newVld[g]   = seen[g-1] ? oldVld[g]  : oldVld[g-1];
    assign newAddrs[g] = seen[g-1] ? oldAddr[g] : oldAddr[g-1];
  end

endmodule

// File: rtl/mkv_table.sv
module mkv_table
  import mkv_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64,
  parameter int SLOTS   = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  mkv_strobe_t                  strobe,
  input  logic [ADDR_W-1:0]            missAddr,
  output logic                         tableHit,
  output logic [SLOTS-1:0]             predVld,
  output logic [SLOTS-1:0][ADDR_W-1:0] predAddr
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [ENTRIES-1:0]             entVld;
  logic [TAG_W-1:0]               entTag  [ENTRIES];
  logic [SLOTS-1:0]               entSv   [ENTRIES];
  logic [SLOTS-1:0][ADDR_W-1:0]   entSucc [ENTRIES];
  logic [ADDR_W-1:0]              prevAddr;

  logic [IDX_W-1:0] curIdx, prevIdx;
  logic [TAG_W-1:0] curTag, prevTag;
  logic             sameIdx, freshHere;
  logic             baseVld, trainHit;
  logic [TAG_W-1:0] baseTag;
  logic [SLOTS-1:0] baseSv, updSv;
  logic [SLOTS-1:0][ADDR_W-1:0] baseSucc, updSucc;

  assign curIdx  = missAddr[IDX_W-1:0];
  assign curTag  = missAddr[ADDR_W-1:IDX_W];
  assign prevIdx = prevAddr[IDX_W-1:0];
  assign prevTag = prevAddr[ADDR_W-1:IDX_W];

  // lookup
  assign tableHit = strobe.lookupEn && entVld[curIdx] && (entTag[curIdx] == curTag);
  assign predVld  = tableHit ? entSv[curIdx] : '0;
  assign predAddr = entSucc[curIdx];

  // training sees the table as it stands after this cycle's insert
  assign sameIdx   = (prevIdx == curIdx);
  assign freshHere = sameIdx && strobe.insertEn;
  assign baseVld   = freshHere ? 1'b1   : entVld[prevIdx];
  assign baseTag   = freshHere ? curTag : entTag[prevIdx];
  assign baseSv    = freshHere ? '0     : entSv[prevIdx];
  assign baseSucc  = entSucc[prevIdx];
  assign trainHit  = strobe.trainEn && baseVld && (baseTag == prevTag);

  mkv_mtf #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_mtf (
    .oldVld   (baseSv),
    .oldAddr  (baseSucc),
    .newAddr  (missAddr),
    .newVld   (updSv),
    .newAddrs (updSucc)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entVld   <= '0;
      prevAddr <= '0;
    end else begin
      if (strobe.insertEn)    entVld[curIdx] <= 1'b1;
      if (strobe.capturePrev) prevAddr <= missAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.insertEn && !(freshHere && trainHit)) begin
      entTag[curIdx] <= curTag;
      entSv[curIdx]  <= '0;
    end
    if (trainHit) begin
      entTag[prevIdx]  <= baseTag;
      entSv[prevIdx]   <= updSv;
      entSucc[prevIdx] <= updSucc;
    end
  end

endmodule

// File: rtl/mkv_pfq.sv
// Request queue: several pushes per cycle in slot order, one pop per handshake.
module mkv_pfq #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int SLOTS  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [SLOTS-1:0]             pushVld,
  input  logic [SLOTS-1:0][ADDR_W-1:0] pushAddr,
  input  logic                         pfReady,
  output logic                         pfValid,
  output logic [ADDR_W-1:0]            pfAddr,
  output logic [$clog2(DEPTH+1)-1:0]   qLevel
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SUM_W = CNT_W + 1;

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr, wrPtrNext;
  logic [CNT_W-1:0]  count, accepted;
  logic              pop;
  logic [SLOTS-1:0]  wEn;
  logic [PTR_W-1:0]  wPtr [SLOTS];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pfValid = (count != '0);
  assign pfAddr  = mem[rdPtr];
  assign qLevel  = count;
  assign pop     = pfValid && pfReady;

  always_comb begin
    accepted  = '0;
    wrPtrNext = wrPtr;
    for (int i = 0; i < SLOTS; i++) begin
      wEn[i]  = 1'b0;
      wPtr[i] = wrPtrNext;
      if (pushVld[i] && ((SUM_W'(count) + SUM_W'(accepted)) < SUM_W'(DEPTH))) begin
        wEn[i]    = 1'b1;
        accepted  = accepted + 1'b1;
        wrPtrNext = bump(wrPtrNext);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtrNext;
      if (pop) rdPtr <= bump(rdPtr);
      count <= count + accepted - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (wEn[i]) mem[wPtr[i]] <= pushAddr[i];
    end
  end

endmodule

// File: rtl/markov_prefetcher.sv
module markov_prefetcher
  import mkv_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64,
  parameter int SLOTS   = 4,
  parameter int QDEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              pfReady,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr
);

  localparam int QL_W = $clog2(QDEPTH + 1);

  mkv_strobe_t                  strobe;
  logic                         tableHit;
  logic [SLOTS-1:0]             predVld;
  logic [SLOTS-1:0][ADDR_W-1:0] predAddr;
  logic [SLOTS-1:0]             pushVld;
  logic [QL_W-1:0]              qLevel;

  mkv_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .missValid (missValid),
    .tableHit  (tableHit),
    .strobe    (strobe)
  );

  mkv_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .SLOTS(SLOTS)) u_table (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .missAddr (missAddr),
    .tableHit (tableHit),
    .predVld  (predVld),
    .predAddr (predAddr)
  );

  assign pushVld = predVld & {SLOTS{strobe.issueEn}};

  mkv_pfq #(.ADDR_W(ADDR_W), .DEPTH(QDEPTH), .SLOTS(SLOTS)) u_q (
    .clk      (clk),
    .rstN     (rstN),
    .pushVld  (pushVld),
    .pushAddr (predAddr),
    .pfReady  (pfReady),
    .pfValid  (pfValid),
    .pfAddr   (pfAddr),
    .qLevel   (qLevel)
  );

endmodule

// File: rtl/mkv_checker.sv
module mkv_checker #(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 4,
  parameter int QDEPTH = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       missValid,
  input logic                       pfReady,
  input logic                       pfValid,
  input logic [ADDR_W-1:0]          pfAddr,
  input logic                       tableHit,
  input logic                       insertEn,
  input logic [SLOTS-1:0]           predVld,
  input logic [$clog2(QDEPTH+1)-1:0] qLevel
);

  assert_reset_empty_R1: assert property (@(posedge clk)
    !rstN |=> (qLevel == '0) && !pfValid);

  assert_miss_silent_R2: assert property (@(posedge clk) disable iff (!rstN)
    missValid && !tableHit && !pfValid |=> !pfValid);

  assert_insert_only_on_miss_R2: assert property (@(posedge clk) disable iff (!rstN)
    insertEn |-> missValid && !tableHit);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && !pfReady |=> pfValid && $stable(pfAddr));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    qLevel <= ($clog2(QDEPTH+1))'(QDEPTH));

  assert_issue_next_R10: assert property (@(posedge clk) disable iff (!rstN)
    missValid && tableHit && (predVld != '0) && (qLevel == '0) |=> pfValid);

endmodule

bind markov_prefetcher mkv_checker #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .QDEPTH(QDEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .missValid (missValid),
  .pfReady   (pfReady),
  .pfValid   (pfValid),
  .pfAddr    (pfAddr),
  .tableHit  (tableHit),
  .insertEn  (strobe.insertEn),
  .predVld   (predVld),
  .qLevel    (qLevel)
);

// File: tb/markov_prefetcher_tb.sv
module markov_prefetcher_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic        pfReady = 1'b1;
  logic        pfValid;
  logic [31:0] pfAddr;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  markov_prefetcher u_dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .pfReady(pfReady), .pfValid(pfValid), .pfAddr(pfAddr)
  );

  localparam logic [31:0] A = 32'h101, B = 32'h102, C = 32'h103, D = 32'h104;
  localparam logic [31:0] E = 32'h105, F = 32'h106, A2 = 32'h141; // A2 shares A's index
  localparam int NV = 18;

  localparam logic [31:0] V_ADDR [NV] = '{A, B, A, C, A, D, A, E, A, C, A, F, A, A2, A2, A, F, A};
  localparam int          V_N    [NV] = '{0, 0, 1, 0, 2, 0, 3, 0, 4, 1, 4, 0, 4, 0,  0,  0, 1, 1};
  localparam logic [31:0] V_EXP  [NV][4] = '{
    '{0,0,0,0}, '{0,0,0,0}, '{B,0,0,0}, '{0,0,0,0}, '{C,B,0,0}, '{0,0,0,0},
    '{D,C,B,0}, '{0,0,0,0}, '{E,D,C,B}, '{A,0,0,0}, '{C,E,D,B}, '{0,0,0,0},
    '{F,C,E,D}, '{0,0,0,0}, '{0,0,0,0}, '{0,0,0,0}, '{A,0,0,0}, '{F,0,0,0}};
  // requirement each vector aims at
  localparam int V_REQ [NV] = '{1, 2, 3, 2, 4, 2, 4, 2, 4, 3, 5, 2, 6, 7, 9, 7, 3, 7};

  function automatic string reqName(input int code);
    case (code)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  9: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // present one miss, then drain with pfReady high and compare the request list
  task automatic runVector(input logic [31:0] addr, input int n,
                           input logic [31:0] e0, input logic [31:0] e1,
                           input logic [31:0] e2, input logic [31:0] e3,
                           input string req);
    logic [31:0] exp [4];
    logic [31:0] got [8];
    int gn;
    exp = '{e0, e1, e2, e3};
    gn = 0;
    @(negedge clk);
    missValid = 1'b1; missAddr = addr;
    @(negedge clk);
    missValid = 1'b0;
    // R10: result visible one cycle after the miss
    check(pfValid == (n > 0), (n > 0) ? "R10" : req, "pfValid after miss",
          32'(pfValid), 32'(n > 0));
    for (int k = 0; k < 6; k++) begin
      if (pfValid && gn < 8) begin got[gn] = pfAddr; gn++; end
      @(negedge clk);
    end
    check(gn == n, req, "request count", 32'(gn), 32'(n));
    for (int k = 0; k < n && k < gn; k++)
      check(got[k] == exp[k], req, "request address", got[k], exp[k]);
  endtask

  task automatic pushMiss(input logic [31:0] addr);
    @(negedge clk);
    missValid = 1'b1; missAddr = addr;
  endtask

  initial begin
    #(10 * 100000);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pfValid == 1'b0, "R1", "pfValid in reset", 32'(pfValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pfValid == 1'b0, "R1", "pfValid after reset", 32'(pfValid), 0);

    // vector walk: training, MRU order, repeat, eviction of oldest, conflicts
    for (int v = 0; v < NV; v++)
      runVector(V_ADDR[v], V_N[v], V_EXP[v][0], V_EXP[v][1], V_EXP[v][2], V_EXP[v][3],
                reqName(V_REQ[v]));

    // R8: backpressure, queue fill and partial drop. A:[F] now, prev = A.
    pfReady = 1'b0;
    pushMiss(B);   // pf A               -> q A
    pushMiss(A);   // pf B,F             -> q A B F
    pushMiss(A);   // pf B,F, F dropped  -> q A B F B
    pushMiss(C);   // pf A, dropped
    @(negedge clk);
    missValid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(pfValid == 1'b1, "R8", "valid held under backpressure", 32'(pfValid), 1);
      check(pfAddr == A, "R8", "head held under backpressure", pfAddr, A);
      @(negedge clk);
    end
    pfReady = 1'b1;
    begin
      logic [31:0] expQ [4];
      logic [31:0] got [8];
      int gn;
      expQ = '{A, B, F, B};
      gn = 0;
      for (int k = 0; k < 7; k++) begin
        if (pfValid && gn < 8) begin got[gn] = pfAddr; gn++; end
        @(negedge clk);
      end
      check(gn == 4, "R8", "queue drain count", 32'(gn), 4);
      for (int k = 0; k < 4 && k < gn; k++)
        check(got[k] == expQ[k], "R8", "queue drain order", got[k], expQ[k]);
    end
    // dropped requests still trained: A:[C,A,B,F]
    runVector(A, 4, C, A, B, F, "R8");

    // R1: reset mid-run clears the table and the previous miss
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(pfValid == 1'b0, "R1", "pfValid after mid-run reset", 32'(pfValid), 0);
    rstN = 1'b1;
    runVector(A, 0, 0, 0, 0, 0, "R1");
    runVector(B, 0, 0, 0, 0, 0, "R1");
    runVector(A, 1, B, 0, 0, 0, "R1");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule